// File: doc/BRIEF.md
# Accumulate and Chain Stage

This block is the final stage of a multiply-accumulate slice. It adds a signed multiplier sum to a 64-bit cascade input from the previous slice, with a run-time choice of sign. It can also add a feedback term taken from its own earlier results. The sum is written to a result register, and that register also drives the cascade output to the next slice. Arithmetic wraps modulo 2^64, and no saturation takes place.

The feedback term depends on two controls. With accumulation enabled, the previous result is fed back. With the rounding preload, the constant 2^N is used instead, which gives biased rounding at the start of an accumulation run. When neither is asserted, the feedback term is zero. A build-time option inserts a second register in the feedback loop. Each result then builds on the result from two cycles earlier, so two independent channels accumulate on alternating cycles. Data and controls pass through an optional input register and an optional pipeline register, and these stay aligned with each other.

Top module: `acc_chain_stage`

## Requirements
- R1: With negate_i low, the result equals chain_i plus sum_i sign-extended to 64 bits, plus the feedback term.
- R2: With negate_i high, the result equals chain_i minus the sign-extended sum_i, plus the feedback term.
- R3: With accum_i and ldconst_i both low, the feedback term is zero, so the result reflects only the current inputs.
- R4: With accum_i high and DOUBLE_ACC=0, the feedback term is the result produced one cycle earlier.
- R5: With ldconst_i high, the feedback term is 2^RND_N in place of any earlier result.
- R6: accum_i and ldconst_i are never high in the same cycle. They may be high in adjacent cycles, and each cycle then follows its own rule.
- R7: With DOUBLE_ACC=1 and accum_i high, the feedback term is the result produced two cycles earlier, so even and odd cycles accumulate separately.
- R8: A set of inputs affects result_o exactly IN_REG+PIPE_REG+1 clock edges after it is sampled, and has no effect on any other cycle's result.
- R9: Additions and subtractions wrap modulo 2^64.
- R10: chain_o carries the full 64-bit result and is equal to result_o in every cycle.
- R11: While rst_ni is low, result_o, chain_o and all internal stages are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sum_i | input | IN_W | Signed multiplier sum |
| chain_i | input | ACC_W | Cascade input from the previous stage |
| negate_i | input | 1 | 1: subtract sum_i from chain_i; 0: add |
| accum_i | input | 1 | Feed the earlier result back |
| ldconst_i | input | 1 | Feed 2^RND_N back instead of a result |
| result_o | output | ACC_W | Accumulated result |
| chain_o | output | ACC_W | Cascade output to the next stage |

## Verification
The assertions assume that accum_i and ldconst_i are never high together, and that the inputs have been driven for at least as many cycles as the latency before any end-to-end property applies. The bench drives a defined value on every clock cycle from the release of reset onward. It never raises both feedback controls in the same cycle, and it places them in adjacent cycles only to exercise the handover between them. A second instance built with the double register receives the same stimulus, so both feedback depths are covered against one reference history.

// File: rtl/acc_chain_pkg.sv
package acc_chain_pkg;
  typedef struct packed {
    logic negate;
    logic accum;
    logic ldconst;
  } acc_ctrl_t;
endpackage

// File: rtl/acc_delay.sv
module acc_delay #(
  parameter int W  = 8,
  parameter bit EN = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (EN) begin : g_reg
    logic [W-1:0] q_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_q <= '0;
      else         q_q <= d_i;
    end
    assign q_o = q_q;
  end else begin : g_wire
    assign q_o = d_i;
  end
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_chain_pkg::*;
#(
  parameter int ACC_W      = 64,
  parameter int RND_N      = 15,
  parameter bit DOUBLE_ACC = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  acc_ctrl_t        ctrl_i,
  input  logic [ACC_W-1:0] sum_i,
  input  logic [ACC_W-1:0] chain_i,
  output logic [ACC_W-1:0] result_o
);
  localparam logic [ACC_W-1:0] RND_CONST = ACC_W'(1) << RND_N;

  logic [ACC_W-1:0] res_q, prev, fb, term;

  if (DOUBLE_ACC) begin : g_dbl
    logic [ACC_W-1:0] hold_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hold_q <= '0;
      else         hold_q <= res_q;
    end
    assign prev = hold_q;
  end else begin : g_sgl
    assign prev = res_q;
  end

  always_comb begin
    if (ctrl_i.ldconst)    fb = RND_CONST;
    else if (ctrl_i.accum) fb = prev;
    else                   fb = '0;
    term = ctrl_i.negate ? (chain_i - sum_i) : (chain_i + sum_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_q <= '0;
    else         res_q <= term + fb;
  end

  assign result_o = res_q;
endmodule

// File: rtl/acc_chain_stage.sv
module acc_chain_stage
  import acc_chain_pkg::*;
#(
  parameter int ACC_W      = 64,
  parameter int IN_W       = 37,
  parameter int RND_N      = 15,
  parameter bit IN_REG     = 1'b1,
  parameter bit PIPE_REG   = 1'b1,
  parameter bit DOUBLE_ACC = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IN_W-1:0]  sum_i,
  input  logic [ACC_W-1:0] chain_i,
  input  logic             negate_i,
  input  logic             accum_i,
  input  logic             ldconst_i,
  output logic [ACC_W-1:0] result_o,
  output logic [ACC_W-1:0] chain_o
);
  localparam int CW = $bits(acc_ctrl_t);
  localparam int BW = CW + 2 * ACC_W;

  acc_ctrl_t        ctrl_in, ctrl_d;
  logic [ACC_W-1:0] sum_ext, sum_d, chain_d;
  logic [BW-1:0]    bus_in, bus_mid, bus_out;

  assign ctrl_in = '{negate: negate_i, accum: accum_i, ldconst: ldconst_i};
  assign sum_ext = {{(ACC_W-IN_W){sum_i[IN_W-1]}}, sum_i};
  assign bus_in  = {ctrl_in, sum_ext, chain_i};

  acc_delay #(.W(BW), .EN(IN_REG)) in_stg_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(bus_in), .q_o(bus_mid));

  acc_delay #(.W(BW), .EN(PIPE_REG)) pipe_stg_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(bus_mid), .q_o(bus_out));

  assign {ctrl_d, sum_d, chain_d} = bus_out;

  acc_core #(.ACC_W(ACC_W), .RND_N(RND_N), .DOUBLE_ACC(DOUBLE_ACC)) core_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_i(ctrl_d),
    .sum_i(sum_d), .chain_i(chain_d), .result_o(result_o));

  assign chain_o = result_o;
endmodule

// File: rtl/acc_chain_stage_chk.sv
module acc_chain_stage_chk #(
  parameter int ACC_W      = 64,
  parameter int IN_W       = 37,
  parameter int RND_N      = 15,
  parameter bit IN_REG     = 1'b1,
  parameter bit PIPE_REG   = 1'b1,
  parameter bit DOUBLE_ACC = 1'b0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [IN_W-1:0]  sum_i,
  input logic [ACC_W-1:0] chain_i,
  input logic             negate_i,
  input logic             accum_i,
  input logic             ldconst_i,
  input logic [ACC_W-1:0] result_o,
  input logic [ACC_W-1:0] chain_o
);
  localparam int LAT = int'(IN_REG) + int'(PIPE_REG) + 1;
  localparam int FBD = DOUBLE_ACC ? 2 : 1;

  logic [2:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           warm_q <= '0;
    else if (warm_q != '1) warm_q <= warm_q + 3'd1;
  end
  logic warm;
  assign warm = int'(warm_q) >= LAT + FBD;

  function automatic logic [ACC_W-1:0] term_f(logic neg, logic [IN_W-1:0] s,
                                              logic [ACC_W-1:0] c);
    logic [ACC_W-1:0] x;
    x = {{(ACC_W-IN_W){s[IN_W-1]}}, s};
    return neg ? c - x : c + x;
  endfunction

  // R6
  excl_ctrl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(accum_i && ldconst_i));

  // R10
  chain_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_o == result_o);

  // R11
  reset_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (result_o == '0));

  // R3
  no_fb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && !$past(accum_i, LAT) && !$past(ldconst_i, LAT)) |->
    result_o == term_f($past(negate_i, LAT), $past(sum_i, LAT), $past(chain_i, LAT)));

  // R5
  rnd_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(ldconst_i, LAT)) |->
    result_o == (ACC_W'(1) << RND_N)
                + term_f($past(negate_i, LAT), $past(sum_i, LAT), $past(chain_i, LAT)));

  // R4 R7
  acc_fb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(accum_i, LAT) && !$past(ldconst_i, LAT)) |->
    result_o == $past(result_o, FBD)
                + term_f($past(negate_i, LAT), $past(sum_i, LAT), $past(chain_i, LAT)));
endmodule

bind acc_chain_stage acc_chain_stage_chk #(
  .ACC_W(ACC_W), .IN_W(IN_W), .RND_N(RND_N),
  .IN_REG(IN_REG), .PIPE_REG(PIPE_REG), .DOUBLE_ACC(DOUBLE_ACC)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .sum_i(sum_i), .chain_i(chain_i),
  .negate_i(negate_i), .accum_i(accum_i), .ldconst_i(ldconst_i),
  .result_o(result_o), .chain_o(chain_o)
);

// File: tb/acc_chain_stage_tb_top.sv
module acc_chain_stage_tb_top;
  localparam int ACC_W = 64;
  localparam int IN_W  = 37;
  localparam int RND_N = 15;
  localparam int LAT   = 3;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [IN_W-1:0]  sum_i = '0;
  logic [ACC_W-1:0] chain_i = '0;
  logic             negate_i = 1'b0, accum_i = 1'b0, ldconst_i = 1'b0;
  logic [ACC_W-1:0] res_s, chn_s, res_d, chn_d;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  acc_chain_stage #(.DOUBLE_ACC(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sum_i(sum_i), .chain_i(chain_i),
    .negate_i(negate_i), .accum_i(accum_i), .ldconst_i(ldconst_i),
    .result_o(res_s), .chain_o(chn_s));

  acc_chain_stage #(.DOUBLE_ACC(1'b1)) dut_dbl_i (
    .clk_i(clk), .rst_ni(rst_ni), .sum_i(sum_i), .chain_i(chain_i),
    .negate_i(negate_i), .accum_i(accum_i), .ldconst_i(ldconst_i),
    .result_o(res_d), .chain_o(chn_d));

  typedef struct {
    int               due;
    logic [ACC_W-1:0] exp_s;
    logic [ACC_W-1:0] exp_d;
    string            tag;
  } item_t;
  item_t sb_q[$];

  logic [ACC_W-1:0] h1s = '0, h1d = '0, h2d = '0;

  task automatic check64(string tag, logic [ACC_W-1:0] act, logic [ACC_W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic neg, logic acc, logic ld, logic [IN_W-1:0] s,
                       logic [ACC_W-1:0] c, string tag);
    logic [ACC_W-1:0] term, fs, fd, rs, rd;
    item_t it;
    @(negedge clk);
    negate_i = neg; accum_i = acc; ldconst_i = ld; sum_i = s; chain_i = c;
    term = neg ? c - {{(ACC_W-IN_W){s[IN_W-1]}}, s} : c + {{(ACC_W-IN_W){s[IN_W-1]}}, s};
    fs = ld ? (ACC_W'(1) << RND_N) : acc ? h1s : '0;
    fd = ld ? (ACC_W'(1) << RND_N) : acc ? h2d : '0;
    rs = term + fs;
    rd = term + fd;
    h1s = rs; h2d = h1d; h1d = rd;
    it.due = cyc + LAT; it.exp_s = rs; it.exp_d = rd; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) drive(0, 0, 0, '0, '0, "R3");
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
        it = sb_q.pop_front();
        if (it.due != cyc) begin
          tests++; fails++;
          $display("FAIL R8 item due %0d missed at cycle %0d", it.due, cyc);
        end else begin
          check64({it.tag, " single"}, res_s, it.exp_s);
          check64({it.tag, " double R7"}, res_d, it.exp_d);
          check64("R10 chain_o", chn_s, res_s);
          check64("R10 chain_o dbl", chn_d, res_d);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : stim
    repeat (4) @(negedge clk);
    // R11: outputs zero under reset
    check64("R11 reset result", res_s, '0);
    check64("R11 reset chain", chn_d, '0);
    rst_ni = 1'b1;
    idle(2);
    // R1: add
    drive(0, 0, 0, 37'd5, 64'd100, "R1");
    drive(0, 0, 0, -37'sd7, 64'd0, "R1");
    drive(0, 0, 0, 37'h0F_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0, "R1");
    // R2: subtract
    drive(1, 0, 0, 37'd250, 64'd1000, "R2");
    drive(1, 0, 0, -37'sd40, 64'd10, "R2");
    // R4/R7: accumulate run
    drive(0, 0, 0, 37'd3, 64'd0, "R4");
    for (int k = 1; k < 7; k++) drive(0, 1, 0, IN_W'(k), 64'd0, "R4");
    drive(1, 1, 0, 37'd2, 64'd50, "R4");
    // R3: feedback off after a run
    drive(0, 0, 0, 37'd9, 64'd1, "R3");
    drive(1, 0, 0, 37'd9, 64'd1, "R3");
    // R5: rounding preload then accumulate
    drive(0, 0, 1, 37'd10, 64'd0, "R5");
    drive(0, 1, 0, 37'd1, 64'd0, "R5");
    drive(0, 1, 0, 37'd1, 64'd0, "R5");
    drive(1, 0, 1, 37'd4, 64'd0, "R5");
    // R7: two interleaved channels
    drive(0, 0, 1, 37'd0, 64'd0, "R7");
    drive(0, 0, 0, 37'd1000, 64'd0, "R7");
    for (int k = 0; k < 6; k++) drive(0, 1, 0, (k % 2) ? 37'd100 : 37'd1, 64'd0, "R7");
    // R6: controls in adjacent cycles, never together
    for (int k = 0; k < 4; k++) begin
      drive(0, 0, 1, 37'd7, 64'd3, "R6");
      drive(0, 1, 0, 37'd5, 64'd2, "R6");
    end
    // R9: wrap
    drive(0, 0, 0, 37'd1, 64'hFFFF_FFFF_FFFF_FFFF, "R9");
    drive(1, 0, 0, 37'd1, 64'd0, "R9");
    drive(0, 0, 0, -37'sd1, 64'd0, "R9");
    drive(0, 1, 0, 37'd2, 64'hFFFF_FFFF_FFFF_FFFF, "R9");
    // R8: isolated pulse between idle cycles
    idle(2);
    drive(0, 0, 0, 37'd77, 64'd23, "R8");
    idle(LAT + 3);
    while (sb_q.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule